// File: doc/BRIEF.md
# USB Frame Timer with Done-Queue Scheduler

This block keeps the frame timing of a USB host controller. A programmable interval sets how many bit times make up a frame. While the bus runs, a counter advances on every bit-time tick, and a readback word reports the bit times left in the current frame. When a frame ends, the block advances a 16-bit frame number, reloads a toggle bit that software uses to spot interval changes, and raises a single-cycle start-of-frame request. The low five bits of the frame number select the periodic list slot for the frame.

The block also decides when the queue of completed transfer descriptors goes back to software. Each descriptor that retires reports a 3-bit delay code, and its address becomes the new head of the done queue. A delay counter keeps the smallest code seen and steps down once per frame. When it reaches zero at a frame end, and no earlier writeback is still waiting for software, the block emits the head on a writeback strobe, empties the queue, rearms the counter and sets a writeback interrupt. Memory traffic and list walking belong to other blocks.

Top module: `usb_frame_sched`

## Requirements
- R1: After reset the interval readback is 32'h27782EDF (interval 11999, largest packet size 0x2778, toggle 0), the frame number is 0, the low-speed threshold is 16'h0628, the writeback interrupt is low and the remaining-time word is 0.
- R2: A write with cfg_sel=0 loads the interval from bits 13:0, the largest packet size from bits 30:16 and the interval toggle from bit 31; the readback returns these fields in the same positions with bits 15:14 reading 0.
- R3: While run_en is high and the bit times elapsed in the frame do not exceed the interval, the remaining-time word is {remaining toggle, 17'b0, interval minus elapsed}; otherwise it is {remaining toggle, 31'b0}.
- R4: A frame spans interval+1 bit-time ticks; at its end the frame number increments modulo 2^16 and the remaining toggle takes the interval toggle.
- R5: sof_irq is high for one cycle after each frame end and never rises while run_en is low.
- R6: slot_idx always equals the low 5 bits of the frame number.
- R7: A retire strobe sets the done head to the retired address with its low 4 bits cleared and sets the delay counter to the smaller of its value and the retire delay code; the counter resets to 7.
- R8: At a frame end where the delay counter is 0 and the writeback interrupt is low, wb_strobe pulses with wb_head equal to the done head with bit 0 set to irq_pend_en; the done head empties, the counter returns to 7 and the writeback interrupt is set.
- R9: At any other frame end the delay counter decrements if it is neither 0 nor 7; a counter of 7 never causes a writeback, and a counter of 0 waits while the writeback interrupt is high.
- R10: wb_ack clears the writeback interrupt; a writeback in the same cycle wins.
- R11: A write with cfg_sel=1 loads the low-speed threshold from bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Bus operational; frames run only while high |
| bit_tick | input | 1 | One pulse per USB bit time |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the interval register, 1 the low-speed threshold |
| cfg_wdata | input | 32 | Register write data |
| retire_vld | input | 1 | A transfer descriptor has retired |
| retire_delay | input | 3 | Interrupt delay code of the retired descriptor |
| retire_addr | input | 32 | Address of the retired descriptor |
| irq_pend_en | input | 1 | Some enabled interrupt is pending |
| wb_ack | input | 1 | Software clears the writeback interrupt |
| fm_interval | output | 32 | Interval register readback |
| ls_thresh | output | 16 | Low-speed threshold readback |
| frame_rem | output | 32 | Remaining-time readback |
| frame_num | output | 16 | Frame number |
| slot_idx | output | 5 | Periodic list slot for this frame |
| sof_irq | output | 1 | Start-of-frame request, one cycle |
| wb_strobe | output | 1 | Done-head writeback strobe |
| wb_head | output | 32 | Done head value written back |
| wb_irq | output | 1 | Writeback interrupt pending |

## Verification
The delay logic is driven with a single retire of code 2, which separates a counter that steps once per frame from one that fires early or late; with two retires in one frame (codes 5 then 1), which shows the minimum is kept and the last address wins; with code 0 while a writeback is unacknowledged, which shows the hold-off; and with code 7, which must never write back. Each writeback is predicted with its head value and the frame number it must appear in, so a strobe in the wrong frame or with the wrong bit 0 is caught. The timer is driven with a paused tick and a shrunken interval to reach the run-out readback, with run_en low to show the start-of-frame request stays silent, and with a one-tick frame over 65536 frames to show the frame number wraps.

// File: rtl/usb_frame_sched.sv
module usb_frame_sched #(
  parameter int          FI_W      = 14,
  parameter logic [13:0] FI_RST    = 14'd11999,
  parameter logic [14:0] FSMPS_RST = 15'h2778,
  parameter logic [15:0] LST_RST   = 16'h0628,
  parameter logic [2:0]  DLY_IDLE  = 3'd7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic        bit_tick,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        retire_vld,
  input  logic [2:0]  retire_delay,
  input  logic [31:0] retire_addr,
  input  logic        irq_pend_en,
  input  logic        wb_ack,
  output logic [31:0] fm_interval,
  output logic [15:0] ls_thresh,
  output logic [31:0] frame_rem,
  output logic [15:0] frame_num,
  output logic [4:0]  slot_idx,
  output logic        sof_irq,
  output logic        wb_strobe,
  output logic [31:0] wb_head,
  output logic        wb_irq
);

  logic [FI_W-1:0] fi, elapsed;
  logic [14:0]     fsmps;
  logic            fit, frt;
  logic [2:0]      dly_cnt, dly_b, dly_n;
  logic [31:0]     done_head;

  wire boundary = run_en & bit_tick & (elapsed >= fi);
  wire wb_fire  = boundary & (dly_cnt == 3'd0) & ~wb_irq;

  always_comb begin
    if (wb_fire)
      dly_b = DLY_IDLE;
    else if (boundary && dly_cnt != 3'd0 && dly_cnt != DLY_IDLE)
      dly_b = dly_cnt - 3'd1;
    else
      dly_b = dly_cnt;
    dly_n = (retire_vld && retire_delay < dly_b) ? retire_delay : dly_b;
  end

  assign fm_interval = {fit, fsmps, 2'b00, fi};
  assign slot_idx    = frame_num[4:0];
  assign frame_rem   = (run_en && elapsed <= fi) ? {frt, 17'd0, fi - elapsed}
                                                 : {frt, 31'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fi        <= FI_RST;
      fsmps     <= FSMPS_RST;
      fit       <= 1'b0;
      frt       <= 1'b0;
      ls_thresh <= LST_RST;
      elapsed   <= '0;
      frame_num <= '0;
      sof_irq   <= 1'b0;
      dly_cnt   <= DLY_IDLE;
      done_head <= '0;
      wb_strobe <= 1'b0;
      wb_head   <= '0;
      wb_irq    <= 1'b0;
    end else begin
      if (cfg_wr && !cfg_sel) begin
        fi    <= cfg_wdata[13:0];
        fsmps <= cfg_wdata[30:16];
        fit   <= cfg_wdata[31];
      end
      if (cfg_wr && cfg_sel)
        ls_thresh <= cfg_wdata[15:0];

      if (!run_en || boundary)
        elapsed <= '0;
      else if (bit_tick)
        elapsed <= elapsed + 1'b1;

      sof_irq <= boundary;
      if (boundary) begin
        frame_num <= frame_num + 16'd1;
        frt       <= fit;
      end

      dly_cnt   <= dly_n;
      wb_strobe <= wb_fire;
      if (wb_fire)
        wb_head <= {done_head[31:1], irq_pend_en};

      if (retire_vld)
        done_head <= {retire_addr[31:4], 4'd0};
      else if (wb_fire)
        done_head <= '0;

      if (wb_fire)
        wb_irq <= 1'b1;
      else if (wb_ack)
        wb_irq <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_frame_sched_chk.sv
module usb_frame_sched_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        retire_vld,
  input logic [2:0]  retire_delay,
  input logic [2:0]  dly_cnt,
  input logic [31:0] frame_rem,
  input logic [15:0] frame_num,
  input logic        sof_irq,
  input logic        wb_strobe,
  input logic        wb_irq
);

  p_frame_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_irq |-> frame_num == $past(frame_num) + 16'd1);

  p_sof_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_irq |-> $past(run_en));

  p_rem_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rem[30:14] == 17'd0);

  p_wb_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> wb_irq && !$past(wb_irq));

  p_wb_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> sof_irq);

  p_retire_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_vld |=> dly_cnt <= $past(retire_delay));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_cnt == 3'd7 && !retire_vld) |=> dly_cnt == 3'd7);

endmodule

bind usb_frame_sched usb_frame_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .retire_vld(retire_vld),
  .retire_delay(retire_delay), .dly_cnt(dly_cnt), .frame_rem(frame_rem),
  .frame_num(frame_num), .sof_irq(sof_irq), .wb_strobe(wb_strobe),
  .wb_irq(wb_irq)
);

// File: tb/usb_frame_sched_tb.sv
module usb_frame_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, bit_tick = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        retire_vld = 1'b0;
  logic [2:0]  retire_delay = '0;
  logic [31:0] retire_addr = '0;
  logic        irq_pend_en = 1'b0, wb_ack = 1'b0;
  logic [31:0] fm_interval, frame_rem, wb_head;
  logic [15:0] ls_thresh, frame_num;
  logic [4:0]  slot_idx;
  logic        sof_irq, wb_strobe, wb_irq;

  int checks = 0, errors = 0, sof_cnt = 0;
  bit done = 0;

  typedef struct packed { logic [31:0] head; logic [15:0] frm; } wb_item_t;
  wb_item_t exp_q[$];

  always #2.5 clk = ~clk;

  usb_frame_sched u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sof_irq) sof_cnt++;
    if (rst_n && wb_strobe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8/R9 unexpected writeback: actual %h expected none", wb_head);
      end else begin
        wb_item_t e;
        e = exp_q.pop_front();
        chk("R8 wb_head", wb_head, e.head);
        chk("R9 wb frame", {16'd0, frame_num}, {16'd0, e.frm});
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic retire(logic [2:0] dly, logic [31:0] a);
    retire_vld = 1'b1; retire_delay = dly; retire_addr = a;
    @(negedge clk);
    retire_vld = 1'b0;
  endtask

  task automatic ack();
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
  endtask

  task automatic wait_sof();
    do @(negedge clk); while (!sof_irq);
  endtask

  task automatic push(logic [31:0] h, logic [15:0] f);
    wb_item_t it;
    it.head = h; it.frm = f;
    exp_q.push_back(it);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] f;
    int s0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk("R1 interval", fm_interval, 32'h27782EDF);
    chk("R1 frame_num", {16'd0, frame_num}, 32'd0);
    chk("R1 ls_thresh", {16'd0, ls_thresh}, 32'h628);
    chk("R1 frame_rem", frame_rem, 32'd0);
    chk("R1 wb_irq", {31'd0, wb_irq}, 32'd0);

    // R2 interval fields, bits 15:14 drop
    wr(1'b0, 32'h8012C009);
    chk("R2 interval readback", fm_interval, 32'h80120009);
    // R11 threshold
    wr(1'b1, 32'h1234ABCD);
    chk("R11 ls_thresh", {16'd0, ls_thresh}, 32'h0000ABCD);
    chk("R2 interval kept", fm_interval, 32'h80120009);

    // R3/R4/R5 timing, frame of 10 ticks
    run_en = 1'b1; bit_tick = 1'b1;
    #1;
    chk("R3 rem at start", frame_rem, 32'h00000009);
    cycles(1);
    chk("R3 rem after one tick", frame_rem, 32'h00000008);
    cycles(9);
    chk("R4 frame_num after 10 ticks", {16'd0, frame_num}, 32'd1);
    chk("R5 sof high", {31'd0, sof_irq}, 32'd1);
    chk("R4 toggle reload", frame_rem, 32'h80000009);
    cycles(1);
    chk("R5 sof single cycle", {31'd0, sof_irq}, 32'd0);
    chk("R3 rem next", frame_rem, 32'h80000008);

    // R3 run-out readback
    bit_tick = 1'b0;
    wr(1'b0, 32'h80120000);
    chk("R3 run out", frame_rem, 32'h80000000);
    wr(1'b0, 32'h00120009);
    chk("R3 rem restored", frame_rem, 32'h80000008);
    bit_tick = 1'b1;
    wait_sof();
    chk("R4 toggle cleared", frame_rem, 32'h00000009);
    chk("R6 slot", {27'd0, slot_idx}, {27'd0, frame_num[4:0]});

    // R5 no sof while stopped
    run_en = 1'b0;
    #1;
    chk("R3 stopped rem", frame_rem, 32'h00000000);
    s0 = sof_cnt;
    cycles(40);
    chk("R5 no sof stopped", sof_cnt, s0);
    run_en = 1'b1;

    // R7/R8 delay code 2
    irq_pend_en = 1'b1;
    wait_sof(); f = frame_num;
    retire(3'd2, 32'h10000A5F);
    push(32'h10000A51, f + 16'd3);
    repeat (4) wait_sof();
    chk("R8 wb_irq set", {31'd0, wb_irq}, 32'd1);

    // R10 ack
    ack();
    chk("R10 wb_irq cleared", {31'd0, wb_irq}, 32'd0);

    // R7 minimum kept, last address wins
    irq_pend_en = 1'b0;
    wait_sof(); f = frame_num;
    retire(3'd5, 32'h20000100);
    retire(3'd1, 32'h20000200);
    push(32'h20000200, f + 16'd2);
    repeat (3) wait_sof();

    // R9 hold-off while interrupt pending
    wait_sof();
    retire(3'd0, 32'h30000040);
    repeat (3) wait_sof();
    chk("R9 irq still pending", {31'd0, wb_irq}, 32'd1);
    chk("R9 no wb while pending", exp_q.size(), 0);
    wait_sof(); f = frame_num;
    ack();
    push(32'h30000040, f + 16'd1);
    repeat (2) wait_sof();

    // R9 code 7 never writes back
    ack();
    wait_sof();
    retire(3'd7, 32'h40000080);
    repeat (4) wait_sof();
    chk("R9 code 7 no writeback", {31'd0, wb_irq}, 32'd0);
    irq_pend_en = 1'b1;
    wait_sof(); f = frame_num;
    retire(3'd0, 32'h50000010);
    push(32'h50000011, f + 16'd1);
    repeat (2) wait_sof();
    chk("R8 irq after wb", {31'd0, wb_irq}, 32'd1);

    // R4 wrap, one-tick frames
    wr(1'b0, 32'h00120000);
    cycles(2);
    f = frame_num;
    cycles(65536);
    chk("R4 frame wrap", {16'd0, frame_num}, {16'd0, f});
    chk("R6 slot after wrap", {27'd0, slot_idx}, {27'd0, f[4:0]});

    chk("R8 all writebacks seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule